// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block brings an asynchronous DRAM up after power-on and keeps its contents alive afterwards. Following reset it holds off for a configurable pause (at least 100 us in real time), then runs a burst of warm-up refresh cycles of the CAS-before-RAS kind, so that the device's internal row counter is exercised. It never drives a row address. Only after the last warm-up cycle has finished does it raise `mem_ready`, and host accesses are expected to stay blocked until then.

In normal operation a free-running interval timer adds one owed refresh every `REF_PERIOD` clocks. A period of 15.6 us covers 4096 rows in 64 ms. While anything is owed, the block holds `arb_req` high towards the access sequencer. When `arb_gnt` is returned, the block takes over the RAS, CAS and WE strobes (`drv_en` high) and plays a fixed sequence. CAS is first held high, then CAS falls, then RAS falls while CAS stays low, and finally both strobes are held high for precharge. WE stays high throughout, which keeps the part out of its test mode.

Refreshes that are not granted stay pending. Up to `MAX_OWED` of them are counted. A tick that arrives while the count is already full sets a sticky overflow flag and is lost. All timing is given in clock cycles through parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, the outputs are in their reset state: `arb_req`=0, `drv_en`=0, `mem_ready`=0, `owed_ovf`=0, and `ras_n`=`cas_n`=`we_n`=1.
- R2: After reset is released, `arb_req` stays low for the pause. Its first high value is seen in the clock cycle after the (`PAUSE_CYC`+2)-th rising edge. Two of those edges belong to the reset synchroniser.
- R3: Exactly `INIT_CNT` refresh cycles (RAS falling edges) occur before `mem_ready` rises. `mem_ready` rises in the cycle right after the recovery phase of the last warm-up cycle.
- R4: A refresh cycle starts (`drv_en` rises) only on the edge after a cycle in which both `arb_req` and `arb_gnt` were high. `drv_en` is never high while `arb_req` is low. While the grant is withheld, no RAS falling edge occurs.
- R5: In each refresh cycle, CAS falls before RAS. CAS is low with RAS high for exactly `T_SETUP` cycles. RAS is then low for exactly `T_STROBE` cycles, and CAS stays low throughout that time.
- R6: Each refresh cycle begins with `T_PRE` cycles of CAS and RAS high with `drv_en` high. It ends with `T_RECOVER` cycles of both strobes high before `drv_en` falls. Whenever `drv_en` is low, both strobes are high.
- R7: `we_n` is high in every cycle of a refresh, including the cycle in which RAS falls.
- R8: After start-up, one refresh becomes owed every `REF_PERIOD` cycles. With the grant always given, the first RAS falling edge comes `REF_PERIOD`+1+`T_PRE`+`T_SETUP` cycles after `mem_ready` is first seen high. After that, RAS falling edges are exactly `REF_PERIOD` cycles apart.
- R9: If the grant is withheld over k interval ticks (k ≤ `MAX_OWED`), giving the grant later produces exactly k refresh cycles, after which `arb_req` falls.
- R10: The count of owed refreshes saturates at `MAX_OWED`. A tick that arrives while the count is full raises `owed_ovf`. Only reset clears `owed_ovf`, and `owed_ovf` stays low while the count has room.
- R11: Once `mem_ready` is high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| arb_gnt | input | 1 | Grant from the access sequencer; expected to stay high while `arb_req` is high |
| arb_req | output | 1 | Refresh wanted, or a refresh cycle is in progress |
| drv_en | output | 1 | This block owns the memory strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| mem_ready | output | 1 | Start-up complete; host accesses allowed |
| owed_ovf | output | 1 | Sticky flag for a lost refresh (owed count already full) |

## Verification
The bench builds the block with `PAUSE_CYC`=20, `REF_PERIOD`=200 and phase lengths of 2, 2, 3 and 2 cycles, with `INIT_CNT` and `MAX_OWED` left at 8. This puts the whole start-up and many refresh intervals within a few thousand cycles. Because eight back-to-back cycles (80 clocks) fit inside half an interval, the bench can withhold the grant across 1, 3, 8 and 9 ticks and predict the exact number of cycles that follow. The ninth tick reaches the saturation point and the overflow flag. Every strobe phase width is measured on each refresh cycle of the run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_PRE     = 3'd1,
    SQ_SETUP   = 3'd2,
    SQ_STROBE  = 3'd3,
    SQ_RECOVER = 3'd4
  } seq_t;
endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic need,
  output logic ovf
);
  localparam int unsigned CW = $clog2(MAX_OWED + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_OWED);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (inc && !dec) begin
      if (cnt_q == FULL) ovf_d = 1'b1;
      else               cnt_d = cnt_q + CW'(1);
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  assign need = (cnt_q != '0);
  assign ovf  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int unsigned T_PRE     = 1,
  parameter int unsigned T_SETUP   = 1,
  parameter int unsigned T_STROBE  = 5,
  parameter int unsigned T_RECOVER = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned M1   = (T_PRE > T_SETUP) ? T_PRE : T_SETUP;
  localparam int unsigned M2   = (T_STROBE > T_RECOVER) ? T_STROBE : T_RECOVER;
  localparam int unsigned TMAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  seq_t          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SQ_IDLE: if (start) begin
        st_d  = SQ_PRE;
        cnt_d = CW'(T_PRE - 1);
      end
      SQ_PRE: if (cnt_q == '0) begin
        st_d  = SQ_SETUP;
        cnt_d = CW'(T_SETUP - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_SETUP: if (cnt_q == '0) begin
        st_d  = SQ_STROBE;
        cnt_d = CW'(T_STROBE - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_STROBE: if (cnt_q == '0) begin
        st_d  = SQ_RECOVER;
        cnt_d = CW'(T_RECOVER - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_RECOVER: if (cnt_q == '0) begin
        st_d  = SQ_IDLE;
      end else cnt_d = cnt_q - CW'(1);
      default: st_d = SQ_IDLE;
    endcase
  end

  assign busy  = (st_q != SQ_IDLE);
  assign done  = (st_q == SQ_RECOVER) && (cnt_q == '0);
  assign cas_n = !((st_q == SQ_SETUP) || (st_q == SQ_STROBE));
  assign ras_n = (st_q != SQ_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC  = 10000,
  parameter int unsigned INIT_CNT   = 8,
  parameter int unsigned REF_PERIOD = 1560,
  parameter int unsigned MAX_OWED   = 8,
  parameter int unsigned T_PRE      = 1,
  parameter int unsigned T_SETUP    = 1,
  parameter int unsigned T_STROBE   = 5,
  parameter int unsigned T_RECOVER  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_gnt,
  output logic arb_req,
  output logic drv_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready,
  output logic owed_ovf
);
  localparam int unsigned IW = $clog2(INIT_CNT + 1);

  logic [1:0]    sync_q;
  logic          rst_i;
  phase_t        ph_q, ph_d;
  logic [IW-1:0] init_q, init_d;
  logic          pause_tick, ivl_tick;
  logic          debt_need, seq_busy, seq_done, need, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i = sync_q[1];

  rfs_timer #(.LEN(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_i), .en(ph_q == PH_PAUSE), .tick(pause_tick)
  );

  rfs_timer #(.LEN(REF_PERIOD)) u_interval (
    .clk(clk), .rst_n(rst_i), .en(ph_q == PH_RUN), .tick(ivl_tick)
  );

  rfs_debt #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk(clk), .rst_n(rst_i), .inc(ivl_tick),
    .dec(seq_done && (ph_q == PH_RUN)),
    .need(debt_need), .ovf(owed_ovf)
  );

  rfs_seq #(
    .T_PRE(T_PRE), .T_SETUP(T_SETUP), .T_STROBE(T_STROBE), .T_RECOVER(T_RECOVER)
  ) u_seq (
    .clk(clk), .rst_n(rst_i), .start(start), .busy(seq_busy),
    .done(seq_done), .ras_n(ras_n), .cas_n(cas_n)
  );

  always_comb begin
    ph_d   = ph_q;
    init_d = init_q;
    unique case (ph_q)
      PH_PAUSE: if (pause_tick) begin
        ph_d   = PH_INIT;
        init_d = IW'(INIT_CNT);
      end
      PH_INIT: if (seq_done) begin
        init_d = init_q - IW'(1);
        if (init_q == IW'(1)) ph_d = PH_RUN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q   <= PH_PAUSE;
      init_q <= '0;
    end else begin
      ph_q   <= ph_d;
      init_q <= init_d;
    end
  end

  assign need      = (ph_q == PH_INIT) || ((ph_q == PH_RUN) && debt_need);
  assign start     = need && arb_gnt && !seq_busy;
  assign arb_req   = need || seq_busy;
  assign drv_en    = seq_busy;
  assign we_n      = 1'b1;
  assign mem_ready = (ph_q == PH_RUN);
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_gnt,
  input logic arb_req,
  input logic drv_en,
  input logic ras_n,
  input logic cas_n,
  input logic mem_ready,
  input logic owed_ovf
);
  assert_grant_before_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(arb_req && arb_gnt));
  assert_no_drive_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_req |-> !drv_en);
  assert_cas_leads_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  assert_cas_covers_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_idle_strobes_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (ras_n && cas_n));
  assert_ready_after_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(drv_en));
  assert_ready_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_ready) |-> mem_ready);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(owed_ovf) |-> owed_ovf);
  assert_ovf_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owed_ovf) |-> $past(arb_req));
endmodule

bind dram_refresh_sched rfs_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arb_gnt(arb_gnt), .arb_req(arb_req),
  .drv_en(drv_en), .ras_n(ras_n), .cas_n(cas_n),
  .mem_ready(mem_ready), .owed_ovf(owed_ovf)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20;
  localparam int INITN = 8;
  localparam int P     = 200;
  localparam int MAXO  = 8;
  localparam int TP = 2, TS = 2, TR = 3, TC = 2;

  logic clk, rst_n, arb_gnt;
  logic arb_req, drv_en, ras_n, cas_n, we_n, mem_ready, owed_ovf;

  int errors = 0, checks = 0;
  int cyc = 0;
  int falls = 0, last_fall = 0, prev_fall = 0;
  int first_req = -1, run_start = -1, falls_at_ready = -1;
  int pre_n = 0, set_n = 0, str_n = 0, rec_n = 0;
  logic after_ras = 1'b0, p_ras = 1'b1, p_cas = 1'b1, p_drv = 1'b0, p_rdy = 1'b0;
  logic rdy_dropped = 1'b0, done_flag = 1'b0;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CNT(INITN), .REF_PERIOD(P), .MAX_OWED(MAXO),
    .T_PRE(TP), .T_SETUP(TS), .T_STROBE(TR), .T_RECOVER(TC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .arb_gnt(arb_gnt), .arb_req(arb_req),
    .drv_en(drv_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .mem_ready(mem_ready), .owed_ovf(owed_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // strobe phase monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (arb_req && first_req < 0) first_req = cyc;
      if (mem_ready && run_start < 0) begin
        run_start = cyc;
        falls_at_ready = falls;
      end
      if (p_rdy && !mem_ready) rdy_dropped = 1'b1;
      if (!drv_en) begin
        if (p_drv) chk(rec_n == TC, "R6 recovery width", rec_n, TC);
        pre_n = 0; set_n = 0; str_n = 0; rec_n = 0; after_ras = 1'b0;
      end else begin
        if (!after_ras && cas_n && ras_n) pre_n++;
        if (!cas_n && ras_n) begin
          if (p_cas) chk(pre_n == TP, "R6 pre-charge width", pre_n, TP);
          set_n++;
        end
        if (!ras_n) begin
          if (p_ras) begin
            chk(set_n == TS, "R5 setup width", set_n, TS);
            chk(we_n == 1'b1, "R7 we_n high", we_n, 1);
            falls++;
            prev_fall = last_fall;
            last_fall = cyc;
          end
          chk(!cas_n, "R5 cas low under ras", cas_n, 0);
          str_n++;
          after_ras = 1'b1;
        end
        if (after_ras && ras_n) begin
          if (!p_ras) chk(str_n == TR, "R5 strobe width", str_n, TR);
          rec_n++;
        end
      end
      p_rdy = mem_ready;
    end
    p_ras = ras_n; p_cas = cas_n; p_drv = drv_en;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_offset(input int off);
    @(negedge clk);
    while (((cyc - run_start) % P) != off) @(negedge clk);
  endtask

  task automatic hold_and_drain(input int k, input string req);
    int f0;
    wait_offset(P/2);
    arb_gnt = 1'b0;
    f0 = falls;
    wait_neg(k * P);
    chk(falls == f0, "R4 no cycle without grant", falls - f0, 0);
    arb_gnt = 1'b1;
    f0 = falls;
    wait_neg(P/2 - 5);
    chk(falls - f0 == k, req, falls - f0, k);
    chk(!arb_req, req, arb_req, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    arb_gnt = 1'b0;
    wait_neg(4);
    chk(arb_req == 0 && drv_en == 0 && mem_ready == 0 && owed_ovf == 0,
        "R1 reset control", {arb_req, drv_en, mem_ready, owed_ovf}, 0);
    chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 7);
    rst_n = 1'b1;
    arb_gnt = 1'b1;
    while (run_start < 0 && cyc < 2000) @(negedge clk);
    chk(first_req == PAUSE + 2, "R2 pause length", first_req, PAUSE + 2);
    chk(falls_at_ready == INITN, "R3 warm-up count", falls_at_ready, INITN);
    chk(!owed_ovf, "R10 no overflow at start", owed_ovf, 0);
    // R8: first interval refresh and spacing
    wait_neg(P + 1 + TP + TS + 2);
    chk(last_fall == run_start + P + 1 + TP + TS, "R8 first interval refresh",
        last_fall - run_start, P + 1 + TP + TS);
    wait_neg(2 * P);
    chk(last_fall - prev_fall == P, "R8 refresh spacing", last_fall - prev_fall, P);
    wait_neg(P);
    chk(last_fall - prev_fall == P, "R8 refresh spacing", last_fall - prev_fall, P);
    // R9: owed refreshes are kept and drained
    hold_and_drain(1, "R9 drain after 1 tick");
    hold_and_drain(3, "R9 drain after 3 ticks");
    hold_and_drain(MAXO, "R9 drain after 8 ticks");
    chk(!owed_ovf, "R10 no overflow at full count", owed_ovf, 0);
    // R10: ninth tick overflows; only MAX_OWED are kept
    begin
      int f0;
      wait_offset(P/2);
      arb_gnt = 1'b0;
      wait_neg(MAXO * P);
      chk(!owed_ovf, "R10 flag low at full count", owed_ovf, 0);
      wait_neg(P);
      chk(owed_ovf, "R10 flag on lost tick", owed_ovf, 1);
      arb_gnt = 1'b1;
      f0 = falls;
      wait_neg(P/2 - 5);
      chk(falls - f0 == MAXO, "R10 saturated drain", falls - f0, MAXO);
      wait_neg(3 * P);
      chk(owed_ovf, "R10 flag sticky", owed_ovf, 1);
    end
    chk(mem_ready && !rdy_dropped, "R11 ready stays high", mem_ready, 1);
    finish_run();
  end
endmodule